// File: doc/BRIEF.md
# Ethernet Transmit Clock Generator

This block produces the MAC transmit clock for an RGMII or RMII PHY. Everything runs in one fast system clock domain, and every clock in the chain is a registered level or a single-cycle tick. Two free-running source tick streams feed a selector. The selected stream goes through a programmable integer divider and then a fixed halving stage. The result is an enable-gated base tick. A link-speed divider turns the base tick into the line clock. In RGMII mode that line clock can be lagged by a quarter, half or three quarters of its own period. In RMII mode the block instead passes the sampled reference clock, either straight or inverted.

A single control word holds every setting. It is written through `cfg_we`/`cfg_wdata` and read back on `cfg_rdata`. The link-speed input changes the output rate directly, with no register write. A new speed is adopted only when a fresh output period begins.

Top module: `ethclk_gen`

## Requirements
- R1: After reset `cfg_rdata` reads 0x084 and `txclk_o` is low. In that value RGMII mode (bit 2) is set, the delay code (bits 8:7) is 1 and every other field is clear.
- R2: Control word layout: bit 0 master enable, bit 1 gate, bit 2 RGMII mode, bit 3 source select, bits 6:4 divide code, bits 8:7 delay code, bit 9 RMII invert. A write with bit 2 set stores the invert bit as 0. A write with bit 2 clear stores the delay code as 0. Every other field is stored as written.
- R3: Source select 0 uses `src_tick0` and 1 uses `src_tick1`; the other stream has no effect. In RGMII mode with delay code 0, each output half-period lasts 2 x D x S source-tick intervals. D is the divide code and S is the speed ratio.
- R4: Divide codes 0 and 1 produce no output edges.
- R5: With the gate bit clear, the RGMII output produces no edges.
- R6: With the master enable clear, `txclk_o` stays low in both modes.
- R7: `link_speed` 2 or 3 gives speed ratio 1, 1 gives ratio 5 and 0 gives ratio 50.
- R8: A `link_speed` change made during the high half of the output takes effect only after the next falling edge. The current high half keeps its old length.
- R9: In RGMII mode the output lags the delay-0 waveform by code x period/4 system cycles once two output half-periods have been measured.
- R10: In RMII mode with enable set, `txclk_o` equals `rmii_ref_i` XOR the invert bit, one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word write data |
| cfg_rdata | output | 10 | Stored control word |
| src_tick0 | input | 1 | Source tick stream 0 |
| src_tick1 | input | 1 | Source tick stream 1 |
| link_speed | input | 2 | Link speed code |
| rmii_ref_i | input | 1 | RMII reference clock, sampled |
| txclk_o | output | 1 | Generated transmit clock |

## Verification
A divider or halving counter holding a wrong value shows up as a high or low half of the wrong length. It is visible at the first complete output period after configuration. A speed ratio latched at the wrong moment stretches or cuts the high half that is in progress, so it is seen at the very next falling edge. A wrong measured half-period, or a wrong lag count, moves every rising edge by a fixed offset. Phase is compared modulo the period against a delay-0 run, so it is caught at the first rising edge examined after the waveform settles.

// File: rtl/ethclk_pkg.sv
package ethclk_pkg;
    localparam int DIV_W = 3;
    localparam int DLY_W = 2;

    typedef struct packed {
        logic             inv;
        logic [DLY_W-1:0] dly;
        logic [DIV_W-1:0] div;
        logic             sel;
        logic             rgmii;
        logic             gate;
        logic             en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    typedef enum logic [1:0] {
        SPD_10M    = 2'd0,
        SPD_100M   = 2'd1,
        SPD_1G     = 2'd2,
        SPD_1G_ALT = 2'd3
    } speed_e;

    localparam ctl_t CTL_RST = '{inv: 1'b0, dly: DLY_W'(1), div: '0, sel: 1'b0,
                                 rgmii: 1'b1, gate: 1'b0, en: 1'b0};
endpackage

// File: rtl/ethclk_regs.sv
module ethclk_regs
    import ethclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl_o
);
    ctl_t ctl_d, ctl_q, req;

    always_comb begin
        req   = ctl_t'(wdata);
        ctl_d = ctl_q;
        if (we) begin
            ctl_d = req;
            // mode-exclusive fields are cleaned at store time
            if (req.rgmii) ctl_d.inv = 1'b0;
            else           ctl_d.dly = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/ethclk_prediv.sv
module ethclk_prediv
    import ethclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick0,
    input  logic             tick1,
    input  logic             sel,
    input  logic [DIV_W-1:0] div,
    input  logic             allow,
    output logic             fire_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
    } st_t;

    st_t  st_d, st_q;
    logic tick, legal;

    always_comb begin
        tick   = sel ? tick1 : tick0;
        legal  = (div >= DIV_MIN);
        st_d   = st_q;
        fire_o = 1'b0;
        if (!legal) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= div - DIV_W'(1)) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                // every second divider wrap is one base tick
                fire_o    = st_q.half & allow;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ethclk_speed.sv
module ethclk_speed
    import ethclk_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int R_GIG  = 1,
    parameter int R_FAST = 5,
    parameter int R_SLOW = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [1:0] spd,
    output logic       raw_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             raw;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] eff;

    function automatic logic [CNT_W-1:0] decode(input logic [1:0] code);
        case (speed_e'(code))
            SPD_10M:  return CNT_W'(R_SLOW);
            SPD_100M: return CNT_W'(R_FAST);
            default:  return CNT_W'(R_GIG);
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        // a new ratio is only taken while a period has not yet started counting
        eff  = (!st_q.raw && st_q.cnt == '0) ? decode(spd) : st_q.ratio;
        st_d.ratio = eff;
        if (fire) begin
            if (st_q.cnt >= eff - CNT_W'(1)) begin
                st_d.cnt = '0;
                st_d.raw = ~st_q.raw;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, ratio: CNT_W'(R_SLOW), raw: 1'b0};
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;
endmodule

// File: rtl/ethclk_phase.sv
module ethclk_phase
    import ethclk_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             en,
    input  logic             rgmii,
    input  logic [DLY_W-1:0] dly,
    input  logic             inv,
    input  logic             ref_i,
    output logic             clk_o
);
    localparam logic [HW-1:0] HCAP = {{(HW-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic          prev;
        logic [HW-1:0] hcnt;
        logic          seen;
        logic          hvalid;
        logic [HW-1:0] lcnt;
        logic          lagd;
        logic          out;
    } st_t;

    st_t           st_d, st_q;
    logic          toggle, lagging;
    logic [HW-1:0] half_len, lval;

    always_comb begin
        st_d     = st_q;
        toggle   = (raw != st_q.prev);
        lagging  = dly[0] & st_q.hvalid;
        half_len = st_q.hcnt + HW'(1);
        lval     = half_len >> 1;
        if (lval == '0) lval = HW'(1);
        st_d.prev = raw;

        // half-period measurement in system cycles
        if (toggle) begin
            st_d.hcnt   = '0;
            st_d.seen   = 1'b1;
            st_d.hvalid = st_q.seen | st_q.hvalid;
        end else if (st_q.hcnt < HCAP) begin
            st_d.hcnt = st_q.hcnt + HW'(1);
        end

        // quarter-period lag: one pending edge at most
        if (!lagging) begin
            st_d.lagd = raw;
            st_d.lcnt = '0;
        end else if (toggle) begin
            if (st_q.lcnt != '0) st_d.lagd = ~st_q.lagd;
            st_d.lcnt = lval;
        end else if (st_q.lcnt == HW'(1)) begin
            st_d.lagd = ~st_q.lagd;
            st_d.lcnt = '0;
        end else if (st_q.lcnt != '0) begin
            st_d.lcnt = st_q.lcnt - HW'(1);
        end

        // half-period lag is an inversion once the period is known
        st_d.out = en & (rgmii ? (st_q.lagd ^ (dly[1] & st_q.hvalid))
                               : (ref_i ^ inv));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o = st_q.out;
endmodule

// File: rtl/ethclk_gen.sv
module ethclk_gen
    import ethclk_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HW     = 16,
    parameter int R_GIG  = 1,
    parameter int R_FAST = 5,
    parameter int R_SLOW = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic [CTL_W-1:0] cfg_rdata,
    input  logic             src_tick0,
    input  logic             src_tick1,
    input  logic [1:0]       link_speed,
    input  logic             rmii_ref_i,
    output logic             txclk_o
);
    ctl_t ctl;
    logic fire_w, raw_w, allow_w;

    assign allow_w   = ctl.gate & ctl.en & ctl.rgmii;
    assign cfg_rdata = ctl;

    ethclk_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctl_o (ctl)
    );

    ethclk_prediv u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick0  (src_tick0),
        .tick1  (src_tick1),
        .sel    (ctl.sel),
        .div    (ctl.div),
        .allow  (allow_w),
        .fire_o (fire_w)
    );

    ethclk_speed #(
        .CNT_W  (CNT_W),
        .R_GIG  (R_GIG),
        .R_FAST (R_FAST),
        .R_SLOW (R_SLOW)
    ) u_speed (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire_w),
        .spd   (link_speed),
        .raw_o (raw_w)
    );

    ethclk_phase #(
        .HW (HW)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_w),
        .en    (ctl.en),
        .rgmii (ctl.rgmii),
        .dly   (ctl.dly),
        .inv   (ctl.inv),
        .ref_i (rmii_ref_i),
        .clk_o (txclk_o)
    );
endmodule

// File: rtl/ethclk_gen_chk.sv
module ethclk_gen_chk
    import ethclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] cfg_rdata,
    input logic             txclk_o,
    input logic             rmii_ref_i,
    input logic             fire,
    input logic             raw
);
    ctl_t c;
    assign c = ctl_t'(cfg_rdata);

    // R2
    rgmii_inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c.rgmii |-> !c.inv);

    // R2
    rmii_dly_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c.rgmii |-> (c.dly == '0));

    // R4
    fire_legal_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (c.div >= DIV_MIN));

    // R5
    fire_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (c.gate && c.en));

    // R3
    raw_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw != $past(raw)) |-> $past(fire));

    // R6
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!c.en) |-> !txclk_o);

    // R10
    rmii_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(c.en && !c.rgmii) |-> (txclk_o == $past(rmii_ref_i ^ c.inv)));
endmodule

bind ethclk_gen ethclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .txclk_o    (txclk_o),
    .rmii_ref_i (rmii_ref_i),
    .fire       (fire_w),
    .raw        (raw_w)
);

// File: tb/sim_ethclk_gen.sv
`timescale 1ns/1ps
module sim_ethclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] cfg_rdata;
    logic       tick0 = 1'b1;
    logic       tick1;
    logic [1:0] spd = 2'd2;
    logic       rref = 1'b0;
    logic       txclk;
    int         cyc = 0;
    int         t1cnt = 0;
    int         total = 0;
    int         fails = 0;

    // {sel, div code, link_speed, expected half-period}; tick0 every cycle, tick1 every 3
    localparam int VEC [6][4] = '{
        '{0, 2, 2, 4},
        '{0, 3, 1, 30},
        '{1, 2, 2, 12},
        '{1, 7, 3, 42},
        '{0, 5, 0, 500},
        '{1, 4, 1, 120}
    };

    always #2.5 clk = ~clk;

    ethclk_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .src_tick0  (tick0),
        .src_tick1  (tick1),
        .link_speed (spd),
        .rmii_ref_i (rref),
        .txclk_o    (txclk)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst_n)          t1cnt <= 0;
        else if (t1cnt == 2) t1cnt <= 0;
        else                 t1cnt <= t1cnt + 1;
    end
    assign tick1 = (t1cnt == 2);

    function automatic logic [9:0] cfgw(input bit en, input bit gate, input bit rg,
                                        input bit sel, input int dv, input int dl,
                                        input bit inv);
        return {inv, 2'(dl), 3'(dv), sel, rg, gate, en};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [9:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_edge(input bit lvl, output int t);
        bit last;
        last = txclk;
        t = -100000;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (txclk == lvl && last != lvl) begin
                t = cyc;
                break;
            end
            last = txclk;
        end
    endtask

    task automatic count_edges(input int n, output int e);
        bit last;
        last = txclk;
        e = 0;
        repeat (n) begin
            @(negedge clk);
            if (txclk != last) e++;
            last = txclk;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, e, bad;
        int ph [4];

        // R1 reset state
        do_reset();
        chk(cfg_rdata == 10'h084, "R1", int'(cfg_rdata), 'h84);
        chk(txclk == 1'b0, "R1", int'(txclk), 0);

        // R2 mode-exclusive fields cleaned on write
        wr(cfgw(0, 0, 1, 0, 2, 2, 1));
        chk(cfg_rdata == cfgw(0, 0, 1, 0, 2, 2, 0), "R2", int'(cfg_rdata),
            int'(cfgw(0, 0, 1, 0, 2, 2, 0)));
        wr(cfgw(0, 0, 0, 1, 5, 3, 1));
        chk(cfg_rdata == cfgw(0, 0, 0, 1, 5, 0, 1), "R2", int'(cfg_rdata),
            int'(cfgw(0, 0, 0, 1, 5, 0, 1)));

        // R3 / R7 vector table
        for (int v = 0; v < 6; v++) begin
            do_reset();
            spd = 2'(VEC[v][2]);
            wr(cfgw(1, 1, 1, VEC[v][0] != 0, VEC[v][1], 0, 0));
            wait_edge(1'b1, t0);
            wait_edge(1'b0, t1);
            wait_edge(1'b1, t2);
            chk(t1 - t0 == VEC[v][3], "R3", t1 - t0, VEC[v][3]);
            chk(t2 - t0 == 2 * VEC[v][3], "R7", t2 - t0, 2 * VEC[v][3]);
        end

        // R4 illegal divide codes
        for (int d = 0; d < 2; d++) begin
            do_reset();
            spd = 2'd2;
            wr(cfgw(1, 1, 1, 0, d, 0, 0));
            count_edges(400, e);
            chk(e == 0, "R4", e, 0);
        end

        // R5 gate clear
        do_reset();
        wr(cfgw(1, 0, 1, 0, 2, 0, 0));
        count_edges(400, e);
        chk(e == 0, "R5", e, 0);

        // R6 master enable clear, RGMII then RMII with a toggling reference
        do_reset();
        wr(cfgw(0, 1, 1, 0, 2, 0, 0));
        count_edges(400, e);
        chk(e == 0, "R6", e, 0);
        wr(cfgw(0, 0, 0, 0, 0, 0, 1));
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) rref = ~rref;
            @(negedge clk);
            if (txclk != 1'b0) bad++;
        end
        chk(bad == 0, "R6", bad, 0);

        // R10 RMII pass-through, straight then inverted
        bad = 0;
        for (int k = 0; k < 2; k++) begin
            wr(cfgw(1, 0, 0, 0, 0, 0, k != 0));
            for (int i = 0; i < 40; i++) begin
                if (i % 5 == 0) rref = ~rref;
                @(negedge clk);
                if (txclk != (rref ^ (k != 0))) bad++;
            end
        end
        chk(bad == 0, "R10", bad, 0);

        // R8 speed change during high half
        do_reset();
        spd = 2'd1;
        wr(cfgw(1, 1, 1, 0, 2, 0, 0));
        wait_edge(1'b1, t0);
        repeat (3) @(negedge clk);
        spd = 2'd0;
        wait_edge(1'b0, t1);
        wait_edge(1'b1, t2);
        wait_edge(1'b0, t3);
        chk(t1 - t0 == 20, "R8", t1 - t0, 20);
        chk(t2 - t1 == 200, "R8", t2 - t1, 200);
        chk(t3 - t2 == 200, "R8", t3 - t2, 200);

        // R9 delay codes: half-period 30, period 60, quarter 15
        for (int c = 0; c < 4; c++) begin
            do_reset();
            spd = 2'd1;
            wr(cfgw(1, 1, 1, 0, 3, c, 0));
            while (cyc < 2000) @(negedge clk);
            wait_edge(1'b1, t0);
            ph[c] = t0 % 60;
        end
        for (int c = 1; c < 4; c++) begin
            chk(((ph[c] - ph[0] + 60) % 60) == 15 * c, "R9",
                (ph[c] - ph[0] + 60) % 60, 15 * c);
        end

        summary();
        $finish;
    end
endmodule